// File: doc/BRIEF.md
# Debug Event Prioritizer

This block sits beside the retire stage of a single-issue core. For each instruction that retires, it decides whether a debug exception is taken. Five kinds of trigger can arrive. An instruction-count trap and an instruction-address breakpoint are generated inside the block. A data-breakpoint hit comes with its comparator index, and the two BREAK instructions (3-byte and 2-byte) are flagged by the decoder. The block owns the instruction counter, its count-level register, and the breakpoint address and enable registers. These registers are loaded through a small write port.

When several triggers land on the same instruction, only one wins and only its cause is recorded. If the current interrupt level is already at or above the debug level, every trigger is masked. On a taken event the block raises a one-cycle take pulse and presents three values: the address of the triggering instruction, the processor-status low bits for debug mode, and the encoded cause. The pipeline flush and the vector fetch are handled elsewhere.

Top module: `dbg_event_arbiter`

## Requirements
- R1: The cause value written on a taken event is: 0x1 for a count trap, 0x2 for an address breakpoint, 0x4 ORed with the comparator index shifted left by 8 for a data breakpoint, 0x8 for the 3-byte BREAK and 0x10 for the 2-byte BREAK.
- R2: When several triggers occur on one retiring instruction, the fixed order of precedence is count trap, address breakpoint, data breakpoint, 3-byte BREAK, 2-byte BREAK, and exactly one cause bit among bits 4:0 is set.
- R3: No event is taken while `cur_level` is greater than or equal to `DBG_LEVEL` (default 6). An event is taken when `cur_level` is lower.
- R4: On a taken event `ps_entry` equals 0x10 ORed with `DBG_LEVEL`.
- R5: On a taken event `saved_pc` equals the `ret_pc` of the triggering instruction.
- R6: The address breakpoint fires only when its enable bit is 1 and `ret_pc` equals the programmed address. The enable resets to 0.
- R7: The counter increments on each retire while `cur_level` is below the count-level register. It traps when that increment produces 0, so a load of -2 from level 0 traps on the second retire.
- R8: With the count-level register at 0, the counter neither changes nor traps.
- R9: `take_dbg` is a one-cycle pulse in the cycle after the triggering retire. `saved_pc`, `ps_entry` and `cause` hold between events. After reset all outputs are 0.
- R10: Register writes use `wr_sel` 0 for the counter (full word), 1 for the count level (low bits), 2 for the breakpoint address and 3 for the breakpoint enable (bit 0). A write wins over a same-cycle increment. Trigger evaluation in that cycle uses the old register values. `icount_val` shows the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | Address of the retiring instruction |
| ret_brk3 | input | 1 | Retiring instruction is the 3-byte BREAK |
| ret_brk2 | input | 1 | Retiring instruction is the 2-byte BREAK |
| dhit | input | 1 | Data breakpoint hit on the retiring instruction |
| dhit_idx | input | IDXW | Index of the matching data comparator |
| cur_level | input | LW | Current interrupt level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | XLEN | Register write data |
| take_dbg | output | 1 | Debug exception taken |
| saved_pc | output | XLEN | Saved debug PC |
| ps_entry | output | 5 | Processor-status low bits on entry |
| cause | output | 8+IDXW | Encoded debug cause |
| icount_val | output | XLEN | Current instruction counter |

## Verification
The count trap and the address breakpoint can both fall on the same retiring instruction, and a BREAK or a data hit can be stacked on top of them. The bench loads the counter with -1 and arms the breakpoint at the PC it then retires with a BREAK flag set. Its cycle-based reference model expects cause 0x1 alone. Other cases remove the winners one at a time, and a further case places a count trap under a masking level, where the counter must still advance and no event may be taken.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CLEVEL = 2'd1,
    SEL_IADDR = 2'd2,
    SEL_IEN = 2'd3
  } dbg_sel_e;

  localparam logic [7:0] CODE_ICOUNT = 8'h01;
  localparam logic [7:0] CODE_IBRK   = 8'h02;
  localparam logic [7:0] CODE_DBRK   = 8'h04;
  localparam logic [7:0] CODE_BRK3   = 8'h08;
  localparam logic [7:0] CODE_BRK2   = 8'h10;
endpackage

// File: rtl/dbg_icount.sv
module dbg_icount #(
  parameter int XLEN = 32,
  parameter int LW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ret_valid,
  input  logic [LW-1:0]   cur_level,
  input  logic            wr_count,
  input  logic            wr_level,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] count_q,
  output logic            trap
);
  logic [LW-1:0]   level_q;
  logic [XLEN-1:0] count_inc;
  logic            counting;

  assign counting  = ret_valid && (cur_level < level_q);
  assign count_inc = count_q + 1'b1;
  assign trap      = counting && (count_inc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      level_q <= '0;
    end else begin
      if (wr_count) count_q <= wr_data;
      else if (counting) count_q <= count_inc;
      if (wr_level) level_q <= wr_data[LW-1:0];
    end
  end

  // R8: without a write or a counted retire the counter keeps its value
  assert_hold_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_count && !(ret_valid && (cur_level < level_q))) |=> $stable(count_q));

  // R7: a trap leaves the counter at zero unless a write replaced it
  assert_trap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    trap |=> (count_q == '0) || $past(wr_count));
endmodule

// File: rtl/dbg_ibreak.sv
module dbg_ibreak #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_addr,
  input  logic            wr_enable,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ret_valid,
  input  logic [XLEN-1:0] ret_pc,
  output logic            hit
);
  logic [XLEN-1:0] addr_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= wr_data;
      if (wr_enable) en_q <= wr_data[0];
    end
  end

  assign hit = ret_valid && en_q && (ret_pc == addr_q);

  // R6: the enable is clear in the first cycle after reset
  assert_en_reset_R6: assert property (@(posedge clk)
    $past(rst) |-> !en_q);
endmodule

// File: rtl/dbg_prio.sv
module dbg_prio #(
  parameter int IDXW = 2,
  parameter int LW = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic            ret_valid,
  input  logic [LW-1:0]   cur_level,
  input  logic            trap,
  input  logic            ihit,
  input  logic            dhit,
  input  logic [IDXW-1:0] dhit_idx,
  input  logic            brk3,
  input  logic            brk2,
  output logic            take,
  output logic [8+IDXW-1:0] code
);
  import dbg_pkg::*;
  localparam int CW = 8 + IDXW;
  localparam logic [LW-1:0] LVL_LIMIT = LW'(DBG_LEVEL);

  logic any_src;

  assign any_src = ret_valid && (trap || ihit || dhit || brk3 || brk2);
  assign take    = any_src && (cur_level < LVL_LIMIT);

  always_comb begin
    if (trap)      code = CW'(CODE_ICOUNT);
    else if (ihit) code = CW'(CODE_IBRK);
    else if (dhit) code = {dhit_idx, CODE_DBRK};
    else if (brk3) code = CW'(CODE_BRK3);
    else if (brk2) code = CW'(CODE_BRK2);
    else           code = '0;
  end
endmodule

// File: rtl/dbg_event_arbiter.sv
module dbg_event_arbiter #(
  parameter int XLEN = 32,
  parameter int LW = 4,
  parameter int IDXW = 2,
  parameter int DBG_LEVEL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_valid,
  input  logic [XLEN-1:0]   ret_pc,
  input  logic              ret_brk3,
  input  logic              ret_brk2,
  input  logic              dhit,
  input  logic [IDXW-1:0]   dhit_idx,
  input  logic [LW-1:0]     cur_level,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  output logic              take_dbg,
  output logic [XLEN-1:0]   saved_pc,
  output logic [4:0]        ps_entry,
  output logic [8+IDXW-1:0] cause,
  output logic [XLEN-1:0]   icount_val
);
  import dbg_pkg::*;
  localparam int CW = 8 + IDXW;
  localparam logic [4:0] PS_ON_ENTRY = 5'h10 | 5'(DBG_LEVEL);
  localparam logic [LW-1:0] LVL_LIMIT = LW'(DBG_LEVEL);

  dbg_sel_e      sel;
  logic          cnt_trap;
  logic          ib_hit;
  logic          take_now;
  logic [CW-1:0] code_now;

  assign sel = dbg_sel_e'(wr_sel);

  dbg_icount #(.XLEN(XLEN), .LW(LW)) u_count (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .cur_level(cur_level),
    .wr_count(wr_en && sel == SEL_COUNT), .wr_level(wr_en && sel == SEL_CLEVEL),
    .wr_data(wr_data), .count_q(icount_val), .trap(cnt_trap)
  );

  dbg_ibreak #(.XLEN(XLEN)) u_ibreak (
    .clk(clk), .rst(rst), .wr_addr(wr_en && sel == SEL_IADDR),
    .wr_enable(wr_en && sel == SEL_IEN), .wr_data(wr_data),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .hit(ib_hit)
  );

  dbg_prio #(.IDXW(IDXW), .LW(LW), .DBG_LEVEL(DBG_LEVEL)) u_prio (
    .ret_valid(ret_valid), .cur_level(cur_level), .trap(cnt_trap),
    .ihit(ib_hit), .dhit(dhit), .dhit_idx(dhit_idx), .brk3(ret_brk3),
    .brk2(ret_brk2), .take(take_now), .code(code_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_dbg <= 1'b0;
      saved_pc <= '0;
      ps_entry <= '0;
      cause    <= '0;
    end else begin
      take_dbg <= take_now;
      if (take_now) begin
        saved_pc <= ret_pc;
        ps_entry <= PS_ON_ENTRY;
        cause    <= code_now;
      end
    end
  end

  assert_mask_R3: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> $past(cur_level) < LVL_LIMIT);
  assert_one_cause_R2: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> $countones(cause[4:0]) == 1);
  assert_ps_entry_R4: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> ps_entry == PS_ON_ENTRY);
  assert_saved_pc_R5: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> saved_pc == $past(ret_pc));
  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> $past(ret_valid));
  assert_hold_cause_R9: assert property (@(posedge clk) disable iff (rst)
    !take_dbg |-> $stable(cause) && $stable(saved_pc));
endmodule

// File: tb/dbg_event_arbiter_tb.sv
`timescale 1ns/1ps
module dbg_event_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ret_valid = 0, ret_brk3 = 0, ret_brk2 = 0, dhit = 0, wr_en = 0;
  logic [31:0] ret_pc = 0, wr_data = 0;
  logic [1:0] dhit_idx = 0, wr_sel = 0;
  logic [3:0] cur_level = 0;
  logic take_dbg;
  logic [31:0] saved_pc, icount_val;
  logic [4:0] ps_entry;
  logic [9:0] cause;

  int errors = 0, checks = 0, cycles = 0;
  string cur_tag = "R9 reset", tag_q = "R9 reset";

  // reference model state
  logic [31:0] m_cnt, m_ia, m_epc;
  int m_cl, m_cause, m_ps;
  logic m_ie, m_take;

  always #2.5 clk = ~clk;

  dbg_event_arbiter dut_i (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_brk3(ret_brk3), .ret_brk2(ret_brk2), .dhit(dhit), .dhit_idx(dhit_idx),
    .cur_level(cur_level), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .take_dbg(take_dbg), .saved_pc(saved_pc), .ps_entry(ps_entry),
    .cause(cause), .icount_val(icount_val)
  );

  always @(posedge clk) begin : model
    logic [31:0] nxt;
    bit counting, ctrap, ih, any;
    tag_q <= cur_tag;
    if (rst) begin
      m_cnt <= 0; m_ia <= 0; m_ie <= 0; m_cl <= 0;
      m_take <= 0; m_epc <= 0; m_ps <= 0; m_cause <= 0;
    end else begin
      nxt = m_cnt + 1;
      counting = ret_valid && (int'(cur_level) < m_cl);
      ctrap = counting && (nxt == 0);
      ih = ret_valid && m_ie && (ret_pc == m_ia);
      any = ret_valid && (ctrap || ih || dhit || ret_brk3 || ret_brk2);
      m_take <= any && (int'(cur_level) < 6);
      if (any && int'(cur_level) < 6) begin
        m_epc <= ret_pc;
        m_ps <= 16 + 6;
        if (ctrap) m_cause <= 1;
        else if (ih) m_cause <= 2;
        else if (dhit) m_cause <= 4 + 256 * int'(dhit_idx);
        else if (ret_brk3) m_cause <= 8;
        else m_cause <= 16;
      end
      if (wr_en && wr_sel == 0) m_cnt <= wr_data;
      else if (counting) m_cnt <= nxt;
      if (wr_en && wr_sel == 1) m_cl <= int'(wr_data[3:0]);
      if (wr_en && wr_sel == 2) m_ia <= wr_data;
      if (wr_en && wr_sel == 3) m_ie <= wr_data[0];
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag_q, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("take_dbg", take_dbg, m_take);
    chk("icount_val R7", icount_val, m_cnt);
    chk("cause R1", cause, m_cause);
    chk("saved_pc R5", saved_pc, m_epc);
    chk("ps_entry R4", ps_entry, m_ps);
  end

  task automatic ret(input logic [31:0] pc, input logic b3, input logic b2,
                     input logic dh, input logic [1:0] di, input logic [3:0] lv,
                     input string tag);
    @(negedge clk);
    wr_en = 0; ret_valid = 1; ret_pc = pc; ret_brk3 = b3; ret_brk2 = b2;
    dhit = dh; dhit_idx = di; cur_level = lv; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; ret_valid = 0; ret_brk3 = 0; ret_brk2 = 0; dhit = 0;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, input string tag);
    @(negedge clk);
    ret_valid = 0; ret_brk3 = 0; ret_brk2 = 0; dhit = 0;
    wr_en = 1; wr_sel = s; wr_data = d; cur_tag = tag;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    idle(2);
    // R1 encodings
    ret(32'h100, 1, 0, 0, 0, 0, "R1 brk3"); idle(2);
    ret(32'h104, 0, 1, 0, 0, 0, "R1 brk2"); idle(2);
    ret(32'h108, 0, 0, 1, 1, 0, "R1 dbrk idx1"); idle(2);
    ret(32'h10c, 0, 0, 1, 3, 2, "R1 dbrk idx3"); idle(2);
    // R3 masking
    ret(32'h110, 1, 0, 0, 0, 6, "R3 level6 masked"); idle(2);
    ret(32'h114, 0, 1, 0, 0, 15, "R3 level15 masked"); idle(2);
    ret(32'h118, 1, 0, 0, 0, 5, "R3 level5 taken"); idle(2);
    // R6 breakpoint gating
    wr(2, 32'h200, "R10 write iaddr");
    ret(32'h200, 0, 0, 0, 0, 0, "R6 disabled match"); idle(2);
    wr(3, 32'h1, "R10 write ien");
    ret(32'h204, 0, 0, 0, 0, 0, "R6 enabled mismatch");
    ret(32'h200, 0, 0, 0, 0, 1, "R6 enabled match"); idle(2);
    // R2 priority stacks
    ret(32'h200, 1, 1, 1, 2, 0, "R2 ibrk over dbrk"); idle(2);
    ret(32'h300, 1, 1, 1, 2, 0, "R2 dbrk over brk"); idle(2);
    ret(32'h300, 1, 1, 0, 0, 0, "R2 brk3 over brk2"); idle(2);
    // R7 count trap on second retire from -2
    wr(0, 32'hFFFF_FFFE, "R10 write count");
    wr(1, 32'h1, "R10 write clevel");
    ret(32'h400, 0, 0, 0, 0, 0, "R7 first retire");
    ret(32'h404, 1, 0, 0, 0, 0, "R7 second retire trap"); idle(2);
    ret(32'h408, 0, 0, 0, 0, 1, "R7 level not below clevel"); idle(1);
    // R2 count trap over breakpoint and BREAK
    wr(0, 32'hFFFF_FFFF, "R10 reload count");
    ret(32'h200, 1, 0, 1, 1, 0, "R2 count over ibrk"); idle(2);
    // R3 count trap under mask still advances
    wr(1, 32'h7, "R10 clevel 7");
    wr(0, 32'hFFFF_FFFF, "R10 reload count");
    ret(32'h500, 0, 0, 0, 0, 6, "R3 masked count trap"); idle(2);
    // R10 write wins over same-cycle increment
    @(negedge clk);
    ret_valid = 1; ret_pc = 32'h600; cur_level = 0; wr_en = 1; wr_sel = 0;
    wr_data = 32'h55; cur_tag = "R10 write vs count";
    idle(2);
    // R8 count level 0 stops counting
    wr(1, 32'h0, "R8 clevel 0");
    wr(0, 32'hFFFF_FFFF, "R8 reload count");
    ret(32'h700, 0, 0, 0, 0, 0, "R8 no trap");
    ret(32'h704, 0, 0, 0, 0, 0, "R8 no trap");
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule